// File: doc/BRIEF.md
# Six-Stage In-Order Pipeline Control

This block tracks control and validity through a six-stage in-order instruction pipeline. The stages, from oldest to youngest, are the write-back (WO), execute (EI), operand fetch (FO), operand-address (CO), decode (DI) and fetch (FI) stages. Each stage register holds a valid bit, an instruction tag, a destination register number, two source register numbers, and three flags: whether the instruction writes its destination, whether it is a branch, and whether that branch is taken. The block does no arithmetic and holds no memory. Only tags and control move through it.

Instructions arrive on a stream port with a valid/ready handshake, at most one per clock. An instruction that reads a register still owed by an older in-flight instruction waits in operand fetch. There is no forwarding, so it stays there until the producer has left the write stage. A taken branch is detected in execute. It empties the four stages behind it, and the source then resends from the branch target. Retirement is reported from the write stage with the tag. A free-running cycle counter is exposed so that a checker can measure latencies.

Top module: `pipe6_core`

## Requirements
- R1: While reset is asserted, all stages are emptied. After reset, retireValid and flushOut are 0, inReady is 1 and cycleCount is 0.
- R2: cycleCount rises by exactly one on every clock edge after reset.
- R3: An instruction is accepted on a clock edge where inValid and inReady are both 1. With no hazard, an instruction accepted on the edge that sets cycleCount to k retires in the cycle where cycleCount is k+5. Nine instructions sent back to back therefore all retire by cycle 14.
- R4: Instructions retire in the order they were accepted. retireValid is 1 and retireTag carries the tag of the instruction in the write stage.
- R5: Take an instruction in operand fetch whose inSrcA or inSrcB equals the destination of a valid instruction in execute or write with inWrites=1. That instruction waits until no such producer remains. Consumers issued 1, 2 or 3 slots after the producer are delayed by 2, 1 and 0 cycles respectively.
- R6: During a dependency stall, inReady is 0, the four front stages keep their contents, and an empty slot enters execute. That empty slot appears as retireValid=0 two cycles later.
- R7: When a valid instruction in execute has inBranch=1 and inTaken=1, flushOut is 1 and inReady is 0 for that cycle. The four younger instructions never retire.
- R8: The taken branch retires on the cycle after flushOut. inReady is 1 on that cycle. An instruction accepted on that cycle retires six cycles after the branch. A branch with inTaken=0 changes nothing.
- R9: When a flush and a dependency stall arise in the same cycle, the flush wins. The stalled consumer is discarded and the target retires six cycles after the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | An instruction is offered |
| inReady | output | 1 | The instruction offered will be accepted on this edge |
| inTag | input | TAG_W | Instruction tag |
| inDst | input | REG_W | Destination register number |
| inSrcA | input | REG_W | First source register number |
| inSrcB | input | REG_W | Second source register number |
| inWrites | input | 1 | 1 = the instruction writes inDst |
| inBranch | input | 1 | 1 = the instruction is a conditional branch |
| inTaken | input | 1 | 1 = the branch resolves as taken |
| retireValid | output | 1 | An instruction retires this cycle |
| retireTag | output | TAG_W | Tag of the retiring instruction |
| flushOut | output | 1 | A taken branch in execute is emptying the front stages |
| cycleCount | output | CNT_W | Clock cycles since reset |

## Verification
A wrong valid bit or a lost hold shows up at the ports within six cycles, as a missing, duplicated, reordered or wrongly timed retirement. The bench therefore logs every retirement with its tag and cycle number and compares the log with the arithmetic latency model. Stall and flush mistakes also show in inReady on the very cycle they occur, so the bench records inReady and flushOut every cycle. It checks them against the stall windows computed for producer distances 1 to 3 and against the flush cycle of the branch.

// File: rtl/pipe6_pkg.sv
package pipe6_pkg;
  parameter int TAG_W = 8;
  parameter int REG_W = 5;

  localparam int N_STAGES = 6;
  localparam int ST_FI = 0;
  localparam int ST_DI = 1;
  localparam int ST_CO = 2;
  localparam int ST_FO = 3;
  localparam int ST_EI = 4;
  localparam int ST_WO = 5;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
    logic             writes;
    logic             isBranch;
    logic             taken;
  } slotT;

  // Strobes from control to the stage registers.
  typedef struct packed {
    logic hold;   // dependency stall, flush not active
    logic flush;  // taken branch in execute
  } ctlT;
endpackage

// File: rtl/pipe6_ctrl.sv
module pipe6_ctrl
  import pipe6_pkg::*;
(
  input  slotT foSlot,
  input  slotT exSlot,
  input  slotT woSlot,
  output ctlT  ctl
);
  function automatic logic owes(slotT prod, slotT cons);
    return prod.valid && prod.writes &&
           (prod.dst == cons.srcA || prod.dst == cons.srcB);
  endfunction

  logic stallReq;
  logic unusedBits;

  always_comb begin
    stallReq  = foSlot.valid && (owes(exSlot, foSlot) || owes(woSlot, foSlot));
    ctl.flush = exSlot.valid && exSlot.isBranch && exSlot.taken;
    ctl.hold  = stallReq && !ctl.flush;
  end

  assign unusedBits = ^{foSlot, exSlot, woSlot};
endmodule

// File: rtl/pipe6_stages.sv
module pipe6_stages
  import pipe6_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlT                       ctl,
  input  logic                      inFire,
  input  slotT                      inSlot,
  output slotT [N_STAGES-1:0]       st
);
  // Fetch stage takes the accepted instruction or an empty slot.
  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush) st[ST_FI] <= '0;
    else if (!ctl.hold)     st[ST_FI] <= inFire ? inSlot : '0;
  end

  // Decode, operand-address and operand-fetch stages shift together.
  for (genvar g = ST_DI; g <= ST_FO; g++) begin : gFront
    always_ff @(posedge clk) begin
      if (!rstN || ctl.flush) st[g] <= '0;
      else if (!ctl.hold)     st[g] <= st[g-1];
    end
  end

  // Execute receives a bubble on stall or flush.
  always_ff @(posedge clk) begin
    if (!rstN || ctl.flush || ctl.hold) st[ST_EI] <= '0;
    else                                st[ST_EI] <= st[ST_FO];
  end

  always_ff @(posedge clk) begin
    if (!rstN) st[ST_WO] <= '0;
    else       st[ST_WO] <= st[ST_EI];
  end
endmodule

// File: rtl/pipe6_core.sv
module pipe6_core
  import pipe6_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [TAG_W-1:0] inTag,
  input  logic [REG_W-1:0] inDst,
  input  logic [REG_W-1:0] inSrcA,
  input  logic [REG_W-1:0] inSrcB,
  input  logic             inWrites,
  input  logic             inBranch,
  input  logic             inTaken,
  output logic             retireValid,
  output logic [TAG_W-1:0] retireTag,
  output logic             flushOut,
  output logic [CNT_W-1:0] cycleCount
);
  ctlT                  ctl;
  slotT                 inSlot;
  slotT [N_STAGES-1:0]  st;
  logic                 inFire;
  logic                 unusedWo;

  assign inSlot = '{valid: 1'b1, tag: inTag, dst: inDst, srcA: inSrcA,
                    srcB: inSrcB, writes: inWrites, isBranch: inBranch,
                    taken: inTaken};

  assign inReady = !ctl.hold && !ctl.flush;
  assign inFire  = inValid && inReady;

  pipe6_ctrl uCtrl (
    .foSlot (st[ST_FO]),
    .exSlot (st[ST_EI]),
    .woSlot (st[ST_WO]),
    .ctl    (ctl)
  );

  pipe6_stages uStages (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .inFire (inFire),
    .inSlot (inSlot),
    .st     (st)
  );

  always_ff @(posedge clk) begin
    if (!rstN) cycleCount <= '0;
    else       cycleCount <= cycleCount + 1'b1;
  end

  assign retireValid = st[ST_WO].valid;
  assign retireTag   = st[ST_WO].tag;
  assign flushOut    = ctl.flush;
  assign unusedWo    = ^st[ST_WO];
endmodule

// File: rtl/pipe6_core_chk.sv
module pipe6_core_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReady,
  input logic             retireValid,
  input logic             flushOut,
  input logic [CNT_W-1:0] cycleCount
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> inReady && !retireValid && !flushOut && cycleCount == '0); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> cycleCount == CNT_W'($past(cycleCount) + 1'b1)); // R2

  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && !flushOut) |=> ##1 !retireValid); // R6

  AST_FLUSH_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |-> !inReady); // R7

  AST_FLUSH_EX_EMPTIED: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> !flushOut); // R7

  AST_FLUSH_BRANCH_RETIRES: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> retireValid && inReady); // R8
endmodule

bind pipe6_core pipe6_core_chk #(.CNT_W(CNT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .inReady     (inReady),
  .retireValid (retireValid),
  .flushOut    (flushOut),
  .cycleCount  (cycleCount)
);

// File: tb/pipe6_core_test.sv
`timescale 1ns/1ps
module pipe6_core_test;
  localparam int TW = 8;
  localparam int RW = 5;
  localparam int CW = 16;
  localparam int RUN_CYC = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [TW-1:0] inTag = '0;
  logic [RW-1:0] inDst = '0, inSrcA = '0, inSrcB = '0;
  logic          inWrites = 1'b0, inBranch = 1'b0, inTaken = 1'b0;
  logic          retireValid;
  logic [TW-1:0] retireTag;
  logic          flushOut;
  logic [CW-1:0] cycleCount;

  pipe6_core #(.CNT_W(CW)) uut (.*);

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  // Program to stream, and logs of what came out.
  int pTag[16], pDst[16], pSa[16], pSb[16];
  bit pWr[16], pBr[16], pTk[16];
  int pLen, pTarget;
  int nLog;
  int logTag[32], logCyc[32];
  bit readyLog[RUN_CYC], flushLog[RUN_CYC];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setInstr(input int k, input int tag, input int dst, input int sa,
                          input int sb, input bit wr, input bit br, input bit tk);
    pTag[k] = tag; pDst[k] = dst; pSa[k] = sa; pSb[k] = sb;
    pWr[k] = wr; pBr[k] = br; pTk[k] = tk;
  endtask

  task automatic runProg();
    int idx;
    rstN = 1'b0; inValid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    nLog = 0; idx = 0;
    for (int c = 0; c < RUN_CYC; c++) begin
      if (retireValid && nLog < 32) begin
        logTag[nLog] = int'(retireTag);
        logCyc[nLog] = int'(cycleCount);
        nLog++;
      end
      readyLog[c] = inReady;
      flushLog[c] = flushOut;
      if (flushOut) idx = pTarget;
      if (idx < pLen) begin
        inTag = TW'(pTag[idx]); inDst = RW'(pDst[idx]);
        inSrcA = RW'(pSa[idx]); inSrcB = RW'(pSb[idx]);
        inWrites = pWr[idx]; inBranch = pBr[idx]; inTaken = pTk[idx];
        inValid = 1'b1;
        if (inReady) idx++;
      end else begin
        inValid = 1'b0;
      end
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic expectRetire(input int k, input int tag, input int cyc, input string req);
    check(k < nLog && logTag[k] == tag, {req, " tag"}, (k < nLog) ? logTag[k] : -1, tag);
    check(k < nLog && logCyc[k] == cyc, {req, " cycle"}, (k < nLog) ? logCyc[k] : -1, cyc);
  endtask

  task automatic countFlushes(output int n);
    n = 0;
    for (int c = 0; c < RUN_CYC; c++) n += int'(flushLog[c]);
  endtask

  initial begin
    int nf;
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(retireValid == 1'b0, "R1 retireValid", int'(retireValid), 0);
    check(inReady == 1'b1, "R1 inReady", int'(inReady), 1);
    check(flushOut == 1'b0, "R1 flushOut", int'(flushOut), 0);
    check(cycleCount == '0, "R1 cycleCount", int'(cycleCount), 0);

    // R3 R4: nine independent instructions back to back
    for (int k = 0; k < 9; k++) setInstr(k, k + 1, k + 1, 0, 0, 1'b1, 1'b0, 1'b0);
    pLen = 9; pTarget = 0;
    runProg();
    check(cycleCount == CW'(RUN_CYC), "R2 cycleCount", int'(cycleCount), RUN_CYC);
    check(nLog == 9, "R3 retire count", nLog, 9);
    for (int k = 0; k < 9; k++) expectRetire(k, k + 1, k + 6, "R3 R4 stream");
    for (int c = 0; c < 12; c++) check(readyLog[c] == 1'b1, "R3 ready", int'(readyLog[c]), 1);

    // R5 R6: consumer 1, 2, 3 slots behind its producer
    for (int d = 1; d <= 3; d++) begin
      setInstr(0, 1, 3, 0, 0, 1'b1, 1'b0, 1'b0);
      for (int j = 1; j < d; j++) setInstr(j, 10 + j, 10 + j, 0, 0, 1'b1, 1'b0, 1'b0);
      setInstr(d, 20, 12, 0, 3, 1'b1, 1'b0, 1'b0);
      setInstr(d + 1, 30, 0, 0, 0, 1'b0, 1'b0, 1'b0);
      pLen = d + 2; pTarget = 0;
      runProg();
      check(nLog == d + 2, "R5 retire count", nLog, d + 2);
      expectRetire(0, 1, 6, "R5 producer");
      for (int j = 1; j < d; j++) expectRetire(j, 10 + j, j + 6, "R5 filler");
      // consumer accepted at edge d+1, delayed by 3-d cycles: always cycle 9
      expectRetire(d, 20, 9, "R5 consumer");
      expectRetire(d + 1, 30, 10, "R6 follower held");
      for (int c = 4; c <= 7; c++)
        check(readyLog[c] == !(c >= d + 4 && c <= 6), "R6 stall ready",
              int'(readyLog[c]), int'(!(c >= d + 4 && c <= 6)));
    end

    // R7 R8: taken branch, four wrong-path instructions, then target
    setInstr(0, 1, 1, 0, 0, 1'b1, 1'b0, 1'b0);
    setInstr(1, 2, 0, 0, 0, 1'b0, 1'b1, 1'b1);
    for (int j = 2; j < 6; j++) setInstr(j, j + 1, j + 1, 0, 0, 1'b1, 1'b0, 1'b0);
    setInstr(6, 7, 8, 0, 0, 1'b1, 1'b0, 1'b0);
    setInstr(7, 8, 9, 0, 0, 1'b1, 1'b0, 1'b0);
    pLen = 8; pTarget = 6;
    runProg();
    countFlushes(nf);
    check(nf == 1 && flushLog[6], "R7 flush cycle", nf, 1);
    check(readyLog[6] == 1'b0, "R7 ready during flush", int'(readyLog[6]), 0);
    check(readyLog[7] == 1'b1, "R8 ready after flush", int'(readyLog[7]), 1);
    check(nLog == 4, "R7 wrong path dropped", nLog, 4);
    expectRetire(0, 1, 6, "R8 older");
    expectRetire(1, 2, 7, "R8 branch");
    expectRetire(2, 7, 13, "R8 target");
    expectRetire(3, 8, 14, "R8 target next");

    // R8: same program, branch not taken
    pTk[1] = 1'b0;
    runProg();
    countFlushes(nf);
    check(nf == 0, "R8 untaken flush", nf, 0);
    check(nLog == 8, "R8 untaken count", nLog, 8);
    for (int k = 0; k < 8; k++) expectRetire(k, k + 1, k + 6, "R8 untaken");

    // R9: flush and stall in the same cycle
    setInstr(0, 1, 5, 0, 0, 1'b1, 1'b1, 1'b1);
    setInstr(1, 2, 6, 5, 0, 1'b1, 1'b0, 1'b0);
    for (int j = 2; j < 5; j++) setInstr(j, j + 1, j + 5, 0, 0, 1'b1, 1'b0, 1'b0);
    setInstr(5, 6, 11, 0, 0, 1'b1, 1'b0, 1'b0);
    pLen = 6; pTarget = 5;
    runProg();
    check(flushLog[5] == 1'b1, "R9 flush taken", int'(flushLog[5]), 1);
    check(readyLog[6] == 1'b1, "R9 no stall after flush", int'(readyLog[6]), 1);
    check(nLog == 2, "R9 retire count", nLog, 2);
    expectRetire(0, 1, 6, "R9 branch");
    expectRetire(1, 6, 12, "R9 target");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule